// File: doc/BRIEF.md
# Board Interrupt Gatherer with Active-Low Status

This block collects up to twenty-four board interrupt lines (MAC and PHY events, mezzanine and PMC signals, management-controller requests, voltage-monitor alarms, watchdog expiry) and merges them into one interrupt line for the processor. Each source line is active-low. Each line is brought into the local clock domain through a two-flop synchroniser. Software sees the synchronised lines as three read-only status bytes, where a 0 means "source active". Three read/write mask bytes decide which sources may reach the merged output. A mask bit of 1 blocks its source, and every mask bit comes out of reset set, so nothing interrupts the processor until software opens the masks.

One status position does not carry an interrupt. It carries the synchronised state of the board's ejector handles: 0 when the handles are open and 1 when they are closed. It never contributes to the merged output. Status positions with no source behind them always read 1. To find the cause of an interrupt, software reads all three status bytes and clears the condition at the source. The block holds no sticky state.

The register bus is byte-wide. Writes take one strobe cycle. Reads return combinationally from the address.

Top module: `irq_gather`

## Requirements
- R1: Mask bytes sit at addresses 0, 1 and 2. Bit b of the byte at address n controls source 8*n+b. A write with `reg_wr`=1 stores `reg_wdata` at the next rising edge, and the byte reads back exactly as written, including bits that have no source.
- R2: After reset every mask bit reads 1.
- R3: A source passes to the merged output only when its mask bit is 0. A mask bit of 1 blocks it.
- R4: Status bytes sit at addresses 4, 5 and 6. Bit b of the byte at address 4+n reflects source 8*n+b: 0 when `src_n` for that source is low (active), 1 when it is high. A change on `src_n` appears in the status two rising edges after it is applied.
- R5: The status bytes are read-only. A write to addresses 4 to 6 changes neither the status read back nor any mask byte.
- R6: `irq_n` is low in the cycle after any rising edge at which some synchronised source is active and unmasked, and high otherwise. A source change therefore reaches `irq_n` three rising edges after it is applied. `irq_n` is high out of reset.
- R7: Positions outside the source set (by default bits 20, 21 and 22) always read 1 in the status and never pull `irq_n` low, whatever their `src_n` level and mask bit.
- R8: Status address 6 bit 7 reports the synchronised `eject_closed` input: 1 when the handles are closed, 0 when open. It never pulls `irq_n` low.
- R9: Addresses 3 and 7 read 0x00, and writes to them change no mask byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_n | input | 24 | Asynchronous active-low interrupt source lines |
| eject_closed | input | 1 | Asynchronous ejector-handle state, 1 when closed |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq_n | output | 1 | Merged interrupt to the processor, active-low |

## Verification
Four properties are checked on every cycle:
- the mask bytes hold all ones at reset release;
- a write lands in its mask byte one edge later;
- the synchronised source vector equals the raw input from two edges earlier;
- `irq_n` never drops without an unmasked enabled source behind it, and never stays low after all enabled sources went inactive.

Some behaviour is shown only by the bench's scenarios:
- the read-back layout of the six bytes;
- status bytes that do not change under writes;
- the three-edge path from a pin change to `irq_n`;
- the isolation of the ejector bit and of the reserved positions;
- zero reads at the unmapped addresses.

// File: rtl/irq_gather_pkg.sv
// Shared constants for the board interrupt gatherer.
// Assumes a register map of 2**k mask slots followed by 2**k status slots.
package irq_gather_pkg;
    localparam int BYTE_W     = 8;
    localparam int SYNC_DEPTH = 2;
    // Reset level of a synchronised active-low line: inactive.
    localparam logic IDLE_LVL = 1'b1;
endpackage

// File: rtl/irq_gather_sync.sv
// Multi-bit synchroniser chain of STAGES flops per bit.
// Assumes every bit is an independent quasi-static level; no bus coherency is implied.
module irq_gather_sync #(
    parameter int   WIDTH  = 25,
    parameter int   STAGES = 2,
    parameter logic RST_LV = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First capture flop of the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= {WIDTH{RST_LV}};
                    else        chain[0] <= d;
                end
            end else begin : g_next
                // Later flops only shift the previous stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= {WIDTH{RST_LV}};
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_gather_mask.sv
// Bank of NUM_REGS read/write mask bytes; every bit resets to 1 (masked).
// Assumes addresses with the top bit clear select mask slots; other addresses are ignored.
module irq_gather_mask #(
    parameter int NUM_REGS = 3,
    parameter int REG_W    = 8,
    parameter int AW       = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [AW-1:0]             addr,
    input  logic [REG_W-1:0]          wdata,
    output logic [NUM_REGS*REG_W-1:0] mask_flat
);
    localparam int IW = AW - 1;

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
            logic [REG_W-1:0] mask_q;
            logic             hit;

            assign hit = wr_en && !addr[AW-1] && (addr[IW-1:0] == IW'(i));

            // Store the written byte; reset to fully masked.
            always_ff @(posedge clk) begin
                if (!rst_n)   mask_q <= '1;
                else if (hit) mask_q <= wdata;
            end

            assign mask_flat[i*REG_W +: REG_W] = mask_q;

            // R2: masks leave reset fully set.
            a_r2_mask_reset_set: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rst_n) |-> mask_q == '1);

            // R1: a write to this slot lands at the next edge.
            a_r1_mask_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && !addr[AW-1] && addr[IW-1:0] == IW'(i)) |=> mask_q == $past(wdata));
        end
    endgenerate
endmodule

// File: rtl/irq_gather_regread.sv
// Builds the active-low status vector and the combinational read mux.
// Assumes act_n and eject are already synchronised; reserved status positions read 1.
module irq_gather_regread #(
    parameter int                            NUM_REGS  = 3,
    parameter int                            REG_W     = 8,
    parameter int                            AW        = 3,
    parameter logic [NUM_REGS*REG_W-1:0]     STAT_USED = '1,
    parameter int                            EJECT_POS = 23
) (
    input  logic [NUM_REGS*REG_W-1:0] act_n,
    input  logic                      eject,
    input  logic [NUM_REGS*REG_W-1:0] mask_flat,
    input  logic [AW-1:0]             addr,
    output logic [REG_W-1:0]          rdata
);
    localparam int NB = NUM_REGS * REG_W;
    localparam int IW = AW - 1;

    logic [NB-1:0] stat_vec;
    logic [IW-1:0] idx;

    // Force unused positions to 1 and place the ejector state.
    always_comb begin
        stat_vec            = act_n | ~STAT_USED;
        stat_vec[EJECT_POS] = eject;
    end

    assign idx = addr[IW-1:0];

    // Select a mask or status byte; unmapped slots read zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (idx == IW'(i)) begin
                rdata = addr[AW-1] ? stat_vec[i*REG_W +: REG_W]
                                   : mask_flat[i*REG_W +: REG_W];
            end
        end
    end
endmodule

// File: rtl/irq_gather.sv
// Top of the board interrupt gatherer: synchronises the sources and the
// ejector state, holds the masks, serves reads and registers the merged
// active-low interrupt.
// Assumes NUM_REGS >= 2, and that EJECT_POS is outside SRC_USED.
module irq_gather
    import irq_gather_pkg::*;
#(
    parameter int                                  NUM_REGS  = 3,
    parameter int                                  REG_W     = BYTE_W,
    parameter logic [NUM_REGS*REG_W-1:0]           SRC_USED  = 24'h0F_FFFF,
    parameter int                                  EJECT_POS = 23,
    localparam int                                 NSRC      = NUM_REGS * REG_W,
    localparam int                                 ADDR_W    = $clog2(NUM_REGS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_n,
    input  logic              eject_closed,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq_n
);
    localparam logic [NSRC-1:0] EJ_ONEHOT = NSRC'(1) << EJECT_POS;
    localparam logic [NSRC-1:0] IRQ_EN    = SRC_USED & ~EJ_ONEHOT;

    logic [NSRC:0]     sync_q;
    logic [NSRC-1:0]   act_n;
    logic              eject_s;
    logic [NSRC-1:0]   mask_flat;
    logic              irq_q;
    logic              pend;
    logic [1:0]        age_q;

    irq_gather_sync #(.WIDTH(NSRC + 1), .STAGES(SYNC_DEPTH), .RST_LV(IDLE_LVL)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({eject_closed, src_n}),
        .q     (sync_q)
    );

    assign act_n   = sync_q[NSRC-1:0];
    assign eject_s = sync_q[NSRC];

    irq_gather_mask #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .AW(ADDR_W)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .mask_flat (mask_flat)
    );

    irq_gather_regread #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W),
        .AW       (ADDR_W),
        .STAT_USED(IRQ_EN),
        .EJECT_POS(EJECT_POS)
    ) u_read (
        .act_n     (act_n),
        .eject     (eject_s),
        .mask_flat (mask_flat),
        .addr      (reg_addr),
        .rdata     (reg_rdata)
    );

    // Any enabled, active and unmasked source requests service.
    assign pend = |(~act_n & ~mask_flat & IRQ_EN);

    // Register the merged request as an active-low output.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b1;
        else        irq_q <= ~pend;
    end

    assign irq_n = irq_q;

    // Count edges since reset, saturating, to qualify the latency check.
    always_ff @(posedge clk) begin
        if (!rst_n)             age_q <= '0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    // R4: synchronised sources equal the pins from two edges earlier.
    a_r4_sync_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> sync_q == $past({eject_closed, src_n}, 2));

    // R6: with no enabled source active, the output is released next cycle.
    a_r6_idle_releases_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (&(act_n | ~IRQ_EN)) |=> irq_n);

    // R3: a low output needs an unmasked enabled position one cycle earlier.
    a_r3_irq_needs_open_mask: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> $past(|(~mask_flat & IRQ_EN)));
endmodule

// File: tb/irq_gather_bench.sv
// Bench for irq_gather: directed corner cases plus seeded random rounds,
// checked against a bench model of the register map.
module irq_gather_bench;
    localparam logic [23:0] USED = 24'h0F_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] src_n = '1;
    logic        eject_closed = 1'b1;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq_n;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] m_mask [3];

    always #10 clk = ~clk;

    irq_gather u_irq_gather (
        .clk(clk), .rst_n(rst_n), .src_n(src_n), .eject_closed(eject_closed),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    function automatic logic [7:0] exp_stat(input int r);
        logic [23:0] v;
        v = src_n | ~USED;
        v[23] = eject_closed;
        return v[r*8 +: 8];
    endfunction

    function automatic logic exp_irq();
        logic [23:0] m;
        m = {m_mask[2], m_mask[1], m_mask[0]};
        return ~|(~src_n & ~m & USED);
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        if (a < 3'd3) m_mask[a] = d;
    endtask

    task automatic check_all(input string tag);
        logic [7:0] d;
        for (int r = 0; r < 3; r++) begin
            rd(3'(r), d);
            check({tag, " R1 mask"}, d, m_mask[r]);
            rd(3'(r + 4), d);
            check({tag, " R4 status"}, d, exp_stat(r));
        end
        check({tag, " R6 irq"}, {7'd0, irq_n}, {7'd0, exp_irq()});
    endtask

    initial begin
        logic [7:0] d;
        void'($urandom(32'd4711));
        for (int r = 0; r < 3; r++) m_mask[r] = 8'hFF;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R2: reset state of masks, status and output
        for (int r = 0; r < 3; r++) begin
            rd(3'(r), d);
            check("R2 mask reset", d, 8'hFF);
        end
        check_all("reset");

        // R3: active source blocked while masked
        src_n[19] = 1'b0;
        tick(3);
        check("R3 masked source", {7'd0, irq_n}, 8'd1);
        wr(3'd2, 8'hF7);
        tick(1);
        check("R3 unmasked source", {7'd0, irq_n}, 8'd0);
        src_n[19] = 1'b1;
        tick(3);

        // R4/R6: latency of status and output
        wr(3'd0, 8'hFE);
        src_n[0] = 1'b0;
        tick(1);
        rd(3'd4, d);
        check("R4 status after 1 edge", d, 8'hFF);
        tick(1);
        rd(3'd4, d);
        check("R4 status after 2 edges", d, 8'hFE);
        check("R6 irq after 2 edges", {7'd0, irq_n}, 8'd1);
        tick(1);
        check("R6 irq after 3 edges", {7'd0, irq_n}, 8'd0);
        src_n[0] = 1'b1;
        tick(3);

        // R5: writes to status addresses ignored
        src_n[9] = 1'b0;
        tick(3);
        wr(3'd5, 8'hFF);
        wr(3'd4, 8'h00);
        wr(3'd6, 8'h00);
        for (int r = 0; r < 3; r++) m_mask[r] = m_mask[r];
        check_all("R5 status write");
        src_n[9] = 1'b1;

        // R7 and R8: reserved and ejector positions with all masks open
        wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd2, 8'h00);
        src_n[22:20] = 3'b000;
        src_n[23] = 1'b0;
        eject_closed = 1'b0;
        tick(3);
        rd(3'd6, d);
        check("R7 R8 status byte 6", d, 8'h7F);
        check("R7 R8 irq stays high", {7'd0, irq_n}, 8'd1);
        eject_closed = 1'b1;
        tick(3);
        rd(3'd6, d);
        check("R8 ejector closed", d, 8'hFF);
        src_n = '1;

        // R9: unmapped addresses
        wr(3'd3, 8'h5A);
        wr(3'd7, 8'hA5);
        rd(3'd3, d);
        check("R9 addr 3", d, 8'h00);
        rd(3'd7, d);
        check("R9 addr 7", d, 8'h00);
        check_all("R9 no side effect");

        // Random rounds
        for (int k = 0; k < 300; k++) begin
            src_n = 24'($urandom) | 24'($urandom);
            eject_closed = 1'($urandom);
            if ($urandom_range(0, 1) == 1) begin
                wr(3'($urandom_range(0, 2)), 8'($urandom));
                tick(2);
            end else begin
                tick(3);
            end
            check_all("random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule